// File: doc/BRIEF.md
# Modulo-6 JK Counter

This block is a 3-bit synchronous counter made of three JK flip-flop stages on one clock. The J and K inputs of each stage come from fixed excitation logic that reads the present state, and each stage moves to its next value by the JK rule: hold, clear, set or invert. It does not use an adder and a compare. Starting from zero, the counter passes through six codes and then wraps. A registered terminal-count flag marks the last code of the cycle.

The same excitation logic also fixes where the two unused codes go, so a state upset recovers within two clocks with no extra logic. A synchronous test-load input can place any 3-bit code into the stages. This lets a test reach the unused codes directly. Reset is synchronous and active-high, and it has priority over load.

Top module: `mod6_jk_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next state is `cnt` = 3'b000 and `tc` = 0.
- R2: With `rst` and `tst_load` low, the counter steps through 000, 001, 010, 011, 100, 101 and then back to 000, one code per clock.
- R3: With `rst` and `tst_load` low, the unused code 110 moves to 111 on the next clock.
- R4: With `rst` and `tst_load` low, the unused code 111 moves to 000 on the next clock.
- R5: `tc` is 1 exactly while `cnt` is 3'b101. It is 0 for every other code, including the unused ones.
- R6: When `tst_load` is high and `rst` is low, the next state is `tst_value`, and counting for that clock is overridden.
- R7: When `rst` and `tst_load` are high in the same cycle, reset wins and the next state is 000.
- R8: The least significant stage (`cnt[0]`) inverts on every clock in which it counts, because both of its JK inputs are tied high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all three stages |
| rst | input | 1 | Synchronous active-high reset to 000 |
| tst_load | input | 1 | Test hook: load `tst_value` on the next edge |
| tst_value | input | 3 | Code placed into the stages when loading |
| cnt | output | 3 | Counter state; bit 2 is the MSB stage |
| tc | output | 1 | Registered flag, high while `cnt` is 101 |

## Verification
Two pairs of functions can meet in one cycle. Reset and the test load can be requested together. A load can also arrive while the terminal-count flag is up, or while the counter sits on an unused code. The bench drives `rst` and `tst_load` together with a non-zero `tst_value` and expects 000 with `tc` low. It also loads 101 while counting, so that `tc` must rise in the same cycle as the loaded value. Each applied cycle is judged against a separate modulo-6 reference model that also encodes the two recovery transitions.

// File: rtl/mod6_pkg.sv
package mod6_pkg;
  localparam int CNT_W = 3;
  typedef logic [CNT_W-1:0] cnt_t;
  localparam cnt_t TERM_CODE = 3'b101;

  typedef struct packed {
    logic j;
    logic k;
  } jk_t;

  function automatic logic jk_rule(input logic q, input jk_t e);
    case ({e.j, e.k})
      2'b00:   return q;
      2'b01:   return 1'b0;
      2'b10:   return 1'b1;
      default: return ~q;
    endcase
  endfunction
endpackage

// File: rtl/mod6_excite.sv
module mod6_excite
  import mod6_pkg::*;
(
  input  cnt_t                  cur,
  output jk_t  [CNT_W-1:0]      exc
);
  always_comb begin
    // stage 0 (LSB): free toggle
    exc[0].j = 1'b1;
    exc[0].k = 1'b1;
    // stage 1
    exc[1].j = cur[0] & ~cur[2];
    exc[1].k = cur[0];
    // stage 2 (MSB)
    exc[2].j = cur[1] & cur[0];
    exc[2].k = cur[0];
  end
endmodule

// File: rtl/jk_stage.sv
module jk_stage
  import mod6_pkg::*;
#(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic ld,
  input  logic ld_val,
  input  jk_t  exc,
  output logic d,
  output logic q
);
  always_comb d = ld ? ld_val : jk_rule(q, exc);

  always_ff @(posedge clk) begin
    if (rst) q <= RST_VAL;
    else     q <= d;
  end

  // both inputs high must invert the stage
  p_toggle_r8: assert property (@(posedge clk) disable iff (rst)
    (!ld && exc.j && exc.k) |=> (q != $past(q)));
endmodule

// File: rtl/mod6_jk_counter.sv
module mod6_jk_counter
  import mod6_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tst_load,
  input  logic [2:0] tst_value,
  output logic [2:0] cnt,
  output logic       tc
);
  jk_t [CNT_W-1:0] exc;
  cnt_t            nxt;
  cnt_t            st;

  mod6_excite u_exc (.cur(st), .exc(exc));

  for (genvar i = 0; i < CNT_W; i++) begin : g_stage
    jk_stage #(.RST_VAL(1'b0)) u_stage (
      .clk   (clk),
      .rst   (rst),
      .ld    (tst_load),
      .ld_val(tst_value[i]),
      .exc   (exc[i]),
      .d     (nxt[i]),
      .q     (st[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) tc <= 1'b0;
    else     tc <= (nxt == TERM_CODE);
  end

  assign cnt = st;

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (cnt == 3'b000 && !tc));
  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!tst_load && cnt < 3'd5) |=> (cnt == cnt_t'($past(cnt) + 3'd1)));
  p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (!tst_load && cnt == 3'd5) |=> (cnt == 3'd0));
  p_unused6_r3: assert property (@(posedge clk) disable iff (rst)
    (!tst_load && cnt == 3'd6) |=> (cnt == 3'd7));
  p_unused7_r4: assert property (@(posedge clk) disable iff (rst)
    (!tst_load && cnt == 3'd7) |=> (cnt == 3'd0));
  p_tc_r5: assert property (@(posedge clk) disable iff (rst)
    tc == (cnt == TERM_CODE));
  p_load_r6: assert property (@(posedge clk) disable iff (rst)
    tst_load |=> (cnt == $past(tst_value)));
  p_prio_r7: assert property (@(posedge clk)
    (rst && tst_load) |=> (cnt == 3'b000));
endmodule

// File: tb/mod6_jk_counter_tb_top.sv
module mod6_jk_counter_tb_top;
  typedef struct {
    logic [2:0] q_exp;
    logic       tc_exp;
    string      tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tst_load = 1'b0;
  logic [2:0] tst_value = 3'b000;
  logic [2:0] cnt;
  logic       tc;

  item_t      sb[$];
  logic [2:0] m_q = 3'b000;
  int         n_chk = 0;
  int         n_bad = 0;
  int         cycles = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  mod6_jk_counter dut_i (
    .clk(clk), .rst(rst), .tst_load(tst_load),
    .tst_value(tst_value), .cnt(cnt), .tc(tc)
  );

  task automatic drive(input logic r, input logic ld, input logic [2:0] v);
    item_t it;
    logic [2:0] nq;
    @(negedge clk);
    rst = r; tst_load = ld; tst_value = v;
    if (r) begin
      nq = 3'd0; it.tag = ld ? "R7" : "R1";
    end else if (ld) begin
      nq = v; it.tag = "R6";
    end else begin
      case (m_q)
        3'd5:    begin nq = 3'd0; it.tag = "R2,R8"; end
        3'd6:    begin nq = 3'd7; it.tag = "R3"; end
        3'd7:    begin nq = 3'd0; it.tag = "R4"; end
        default: begin nq = m_q + 3'd1; it.tag = "R2,R8"; end
      endcase
    end
    m_q = nq;
    it.q_exp = nq;
    it.tc_exp = (nq == 3'b101);
    sb.push_back(it);
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      n_chk++;
      if (cnt !== it.q_exp) begin
        n_bad++;
        $display("FAIL %s cnt actual=%b expected=%b", it.tag, cnt, it.q_exp);
      end
      n_chk++;
      if (tc !== it.tc_exp) begin
        n_bad++;
        $display("FAIL R5 tc actual=%b expected=%b (state %b)", tc, it.tc_exp, it.q_exp);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<=20000 cycles", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    drive(1'b1, 1'b0, 3'd0);                                   // R1
    drive(1'b1, 1'b0, 3'd0);
    for (int i = 0; i < 40; i++) drive(1'b0, 1'b0, 3'd0);      // R2, R8
    drive(1'b1, 1'b1, 3'd6);                                   // R7
    for (int v = 0; v < 8; v++) begin                          // R3, R4, R6
      drive(1'b0, 1'b1, 3'(v));
      drive(1'b0, 1'b0, 3'd0);
      drive(1'b0, 1'b0, 3'd0);
    end
    drive(1'b0, 1'b0, 3'd0);
    drive(1'b0, 1'b1, 3'd5);                                   // R6 with R5
    drive(1'b0, 1'b1, 3'd6);                                   // R3 path
    drive(1'b0, 1'b0, 3'd0);
    drive(1'b0, 1'b0, 3'd0);
    drive(1'b1, 1'b1, 3'd5);                                   // R7 from 5
    drive(1'b0, 1'b1, 3'd7);
    drive(1'b1, 1'b0, 3'd0);                                   // R1 mid-run
    for (int i = 0; i < 20; i++) drive(1'b0, 1'b0, 3'd0);
    @(negedge clk); rst = 1'b0; tst_load = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule